// File: doc/BRIEF.md
# One-Hot Residue Rotate Unit

This block works on small residues held in one-hot form. A value in the range 0 to M-1 is carried on M lines, and exactly the line whose index equals the value is high. The unit takes a one-hot data operand and a one-hot shift operand and returns a registered one-hot result. The result is the data rotated by the shift amount, rotated the other way, or mapped through a residue product, chosen by a two-bit operation code. The only arithmetic inside is line permutation selected by the shift lines. There is no binary adder and no carry chain.

A one-hot check flags any operand that does not have exactly one active line. Two small converters are included for test and integration. One turns a binary value into one-hot lines. The other turns the registered result back into binary. The default modulus is 5.

Top module: `ohr_rotate_unit`

## Requirements
- R1: `res_valid` is high in the cycle after each cycle in which `in_valid` was high and low otherwise, and the result registers update at that same edge.
- R2: With `op` = 0 (add) and clean operands, the single active line of `res_oh` has index (d + s) mod M, where d and s are the active line indices of `data_oh` and `shift_oh`.
- R3: With `op` = 1 (subtract), the active result line has index (d - s) mod M.
- R4: With `op` = 2 (multiply), the active result line has index (d * s) mod M.
- R5: With `op` = 3 (pass), the result equals `data_oh`, and `shift_oh` has no effect, including when it has no active line.
- R6: If `data_oh` does not have exactly one active line, or `shift_oh` does not have exactly one active line while `op` is 0, 1 or 2, then at the next edge `res_err` is 1 and `res_oh` is all zeros. A clean input sets `res_err` to 0.
- R7: Between two consecutive valid, error-free results, at most two lines of `res_oh` differ.
- R8: While `in_valid` is low, `res_oh` and `res_err` keep their values.
- R9: `tst_oh` has only line v high when `tst_bin` = v < M, and all lines low for v >= M.
- R10: `res_bin` is the index of the active line of `res_oh`, and 0 when no line is active.
- R11: After reset, `res_valid` = 0, `res_err` = 0 and `res_oh` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| op | input | 2 | 0 add, 1 subtract, 2 multiply, 3 pass |
| data_oh | input | M | One-hot data operand |
| shift_oh | input | M | One-hot shift operand |
| res_valid | output | 1 | Result valid |
| res_oh | output | M | Registered one-hot result |
| res_err | output | 1 | Operand was not one-hot |
| res_bin | output | clog2(M) | Binary index of the result line |
| tst_bin | input | clog2(M) | Binary value to convert |
| tst_oh | output | M | One-hot form of `tst_bin` |

## Verification
On every cycle the assertions check the one-cycle valid latency, that a clean result has exactly one active line, the error flag for malformed data, that the result holds while idle, and the two-line toggle bound between consecutive clean results. They also check that the encoder gives one active line for in-range values. The numeric correctness of add, subtract and multiply for particular operand pairs, including wrap-around at the modulus, can only be shown by the bench's vector table. The same holds for the pass mode ignoring an empty shift operand and for the converters' out-of-range and empty cases.

// File: rtl/ohr_pkg.sv
package ohr_pkg;

    localparam int DEF_MOD = 5;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_MUL  = 2'd2,
        OP_PASS = 2'd3
    } op_e;

endpackage

// File: rtl/ohr_bin2oh.sv
module ohr_bin2oh #(
    parameter int M = ohr_pkg::DEF_MOD,
    localparam int W = $clog2(M)
) (
    input  logic [W-1:0] bin,
    output logic [M-1:0] oh
);
    localparam logic [W:0] MW = (W+1)'(M);

    always_comb begin
        for (int i = 0; i < M; i++) begin
            oh[i] = (bin == W'(i));
        end
    end

    always_comb begin
        if ({1'b0, bin} < MW) begin
            AST_ENC_ONEHOT: assert ($onehot(oh)); // R9
        end
    end
endmodule

// File: rtl/ohr_oh2bin.sv
module ohr_oh2bin #(
    parameter int M = ohr_pkg::DEF_MOD,
    localparam int W = $clog2(M)
) (
    input  logic [M-1:0] oh,
    output logic [W-1:0] bin
);
    always_comb begin
        bin = '0;
        for (int i = 0; i < M; i++) begin
            if (oh[i]) bin = bin | W'(i);
        end
    end
endmodule

// File: rtl/ohr_shift_core.sv
module ohr_shift_core
    import ohr_pkg::*;
#(
    parameter int M = DEF_MOD
) (
    input  op_e          op,
    input  logic [M-1:0] data,
    input  logic [M-1:0] shift,
    output logic [M-1:0] result
);
    logic [M-1:0] cand [M];
    logic [M-1:0] rot;

    for (genvar k = 0; k < M; k++) begin : g_amt
        logic [M-1:0] c;
        always_comb begin
            c = '0;
            for (int i = 0; i < M; i++) begin
                case (op)
                    OP_ADD:  c[(i + k) % M]     = c[(i + k) % M]     | data[i];
                    OP_SUB:  c[(i + M - k) % M] = c[(i + M - k) % M] | data[i];
                    OP_MUL:  c[(i * k) % M]     = c[(i * k) % M]     | data[i];
                    default: c[i]               = c[i]               | data[i];
                endcase
            end
        end
        assign cand[k] = c;
    end

    always_comb begin
        rot = '0;
        for (int k = 0; k < M; k++) begin
            if (shift[k]) rot = rot | cand[k];
        end
    end

    assign result = (op == OP_PASS) ? data : rot;
endmodule

// File: rtl/ohr_rotate_unit.sv
module ohr_rotate_unit
    import ohr_pkg::*;
#(
    parameter int M = DEF_MOD,
    localparam int W = $clog2(M)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [1:0]   op,
    input  logic [M-1:0] data_oh,
    input  logic [M-1:0] shift_oh,
    output logic         res_valid,
    output logic [M-1:0] res_oh,
    output logic         res_err,
    output logic [W-1:0] res_bin,
    input  logic [W-1:0] tst_bin,
    output logic [M-1:0] tst_oh
);
    op_e          op_s;
    logic [M-1:0] core_out;
    logic         bad;

    assign op_s = op_e'(op);

    ohr_shift_core #(.M(M)) u_core (
        .op     (op_s),
        .data   (data_oh),
        .shift  (shift_oh),
        .result (core_out)
    );

    assign bad = !$onehot(data_oh) || ((op_s != OP_PASS) && !$onehot(shift_oh));

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_oh    <= '0;
            res_err   <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                res_err <= bad;
                res_oh  <= bad ? '0 : core_out;
            end
        end
    end

    ohr_oh2bin #(.M(M)) u_dec (.oh(res_oh), .bin(res_bin));
    ohr_bin2oh #(.M(M)) u_enc (.bin(tst_bin), .oh(tst_oh));

    AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid); // R1
    AST_IDLE_LAT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid); // R1
    AST_RES_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_err) |-> $onehot(res_oh)); // R2
    AST_BAD_DATA: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !$onehot(data_oh)) |=> (res_err && res_oh == '0)); // R6
    AST_TOGGLE_TWO: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_err && $past(res_valid) && !$past(res_err))
        |-> ($countones(res_oh ^ $past(res_oh)) <= 2)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res_oh) && $stable(res_err))); // R8
endmodule

// File: tb/sim_ohr_rotate_unit.sv
module sim_ohr_rotate_unit;
    localparam int M = 5;
    localparam int W = 3;
    localparam int NV = 13;
    // fields: op[10:9] d[8:6] s[5:3] expected[2:0]
    localparam logic [10:0] VEC [NV] = '{
        {2'd0, 3'd2, 3'd4, 3'd1},
        {2'd0, 3'd0, 3'd0, 3'd0},
        {2'd0, 3'd3, 3'd1, 3'd4},
        {2'd0, 3'd4, 3'd4, 3'd3},
        {2'd1, 3'd1, 3'd3, 3'd3},
        {2'd1, 3'd0, 3'd0, 3'd0},
        {2'd1, 3'd4, 3'd1, 3'd3},
        {2'd1, 3'd0, 3'd4, 3'd1},
        {2'd2, 3'd3, 3'd4, 3'd2},
        {2'd2, 3'd2, 3'd0, 3'd0},
        {2'd2, 3'd4, 3'd4, 3'd1},
        {2'd2, 3'd3, 3'd3, 3'd4},
        {2'd3, 3'd2, 3'd4, 3'd2}
    };

    logic clk = 0, rst = 1, in_valid = 0;
    logic [1:0] op = 0;
    logic [M-1:0] data_oh = 0, shift_oh = 0;
    logic res_valid, res_err;
    logic [M-1:0] res_oh, tst_oh;
    logic [W-1:0] res_bin, tst_bin = 0;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ohr_rotate_unit #(.M(M)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .data_oh(data_oh), .shift_oh(shift_oh), .res_valid(res_valid),
        .res_oh(res_oh), .res_err(res_err), .res_bin(res_bin),
        .tst_bin(tst_bin), .tst_oh(tst_oh)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [M-1:0] toh(input int v);
        return (v < M) ? (M'(1) << v) : '0;
    endfunction

    task automatic apply(input logic [1:0] o, input logic [M-1:0] d, input logic [M-1:0] s);
        @(negedge clk);
        op = o; data_oh = d; shift_oh = s; in_valid = 1;
        @(posedge clk); #1;
    endtask

    initial begin
        logic [M-1:0] prev;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(posedge clk); #1;
        chk("R11 valid", res_valid, 0);
        chk("R11 err", res_err, 0);
        chk("R11 res", res_oh, 0);

        prev = res_oh;
        for (int n = 0; n < NV; n++) begin
            apply(VEC[n][10:9], toh(VEC[n][8:6]), toh(VEC[n][5:3]));
            chk("R1 valid", res_valid, 1);
            chk($sformatf("R2/R3/R4/R5 vec %0d", n), res_oh, toh(VEC[n][2:0]));
            chk("R10 bin", res_bin, VEC[n][2:0]);
            chk("R6 clean", res_err, 0);
            chk("R7 toggle", ($countones(res_oh ^ prev) <= 2), 1);
            prev = res_oh;
        end

        // R5: pass ignores an empty shift operand
        apply(2'd3, toh(4), '0);
        chk("R5 pass empty shift", res_oh, toh(4));
        chk("R5 no err", res_err, 0);

        // R8: hold while idle
        @(negedge clk); in_valid = 0; data_oh = toh(1); op = 0; shift_oh = toh(1);
        repeat (2) @(posedge clk); #1;
        chk("R1 idle valid", res_valid, 0);
        chk("R8 hold", res_oh, toh(4));

        // R6: malformed data and shift
        apply(2'd0, 5'b00011, toh(1));
        chk("R6 two-hot data err", res_err, 1);
        chk("R6 zero result", res_oh, 0);
        chk("R10 empty bin", res_bin, 0);
        apply(2'd1, toh(2), '0);
        chk("R6 empty shift err", res_err, 1);
        apply(2'd2, '0, toh(2));
        chk("R6 empty data err", res_err, 1);
        apply(2'd0, toh(2), toh(3));
        chk("R6 clear err", res_err, 0);
        chk("R2 wrap", res_oh, toh(0));
        @(negedge clk); in_valid = 0;

        // R9: encoder over all codes
        for (int v = 0; v < 8; v++) begin
            tst_bin = W'(v);
            #1;
            chk($sformatf("R9 enc %0d", v), tst_oh, toh(v));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule